// File: doc/BRIEF.md
# Frame Mailbox Network Interface

This block is a small network interface that a host drives one byte at a time through a register bus. It owns a receive buffer and a transmit buffer, each large enough for one frame. A frame that arrives on the byte-stream input is stored whole and announced with an interrupt. The host then pulls it out byte by byte. In the other direction, the host first writes a frame length and then the bytes one by one. Once the last byte is written, the block plays the frame out on the byte-stream output, one byte per clock.

A busy flag and a three-bit interrupt control register set the pace. Each completed frame sets a done bit and raises busy. The host clears done bits by writing to the control register. Busy then follows whether any bit is still set. A new receive frame is taken only while busy is low. One write code performs a soft reset of the whole block and leaves a self-test interrupt pending. That self-test bit clears on the next read of the control register.

The receive side has two states. In RX_IDLE it waits for a start-marked beat. RX_IDLE moves to RX_CAPTURE on a start beat that is not also an end beat, and RX_CAPTURE returns to RX_IDLE on the end beat. A single-beat frame commits without leaving RX_IDLE.

The transmit side also has two states. In TX_FILL the host writes bytes. TX_FILL moves to TX_PLAY on the write that reaches the programmed length. TX_PLAY returns to TX_FILL after the last byte has been driven. A soft reset forces both sides back to their idle states.

Top module: `fmbx_nic`

## Requirements
- R1: After reset, busy reads 1, both counts and the interrupt control register read 0, `irq` is low, offset 0x00 returns parameter `ID_WORD0` and offset 0x04 returns `ID_WORD1`.
- R2: Only the low 6 address bits are decoded, so 0x48 aliases 0x08. The following all read as 0: offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14, plus 0x18 (info), 0x1C when the receive buffer is empty, and 0x20. Writes to 0x00, 0x04, 0x08, 0x0C, 0x18, 0x1C or to unmapped offsets change nothing.
- R3: A start-marked beat opens a receive frame only when busy is 0 and the receive count (0x0C) is below `MAX_FRAME`. In RX_IDLE, `rx_ready` shows exactly this condition. Beats that are refused, and beats in RX_IDLE without a start marker, are dropped.
- R4: On the end-marked beat, the receive count becomes the frame length, the receive read position returns to the first byte, RXDONE (bit 1 of 0x14) sets and busy becomes 1.
- R5: Each read of 0x1C while the receive count is nonzero returns the next byte in arrival order and decrements the count. When the count is 0, the read returns 0.
- R6: A receive frame longer than `MAX_FRAME` keeps only its first `MAX_FRAME` bytes, and its count is capped at `MAX_FRAME`.
- R7: A write to 0x10 loads the transmit count with the written value if that value is at most `MAX_FRAME`, and with 0 otherwise. The write also restarts the transmit write position. 0x10 reads back the count.
- R8: A write to 0x20 stores bits 7:0 of the write data. The write that brings the number of stored bytes up to the count starts playback, clears the count, sets TXDONE (bit 0 of 0x14) and sets busy. Writes to 0x20 while the count is 0 are ignored.
- R9: Playback drives the stored bytes in write order on consecutive cycles with `tx_valid` high. `tx_sop` marks the first byte and `tx_eop` the last. Writes to 0x20 during playback are ignored, while writes to 0x10 still take effect.
- R10: A write to 0x14 acts by priority. If bit 0 is set, it clears TXDONE only. Otherwise, if bit 1 is set, it clears RXDONE only. Otherwise, if bit 31 is set, it resets all counts, positions and interrupt bits and then sets TEST (bit 31). A write of 0 changes no bit. After any write to 0x14, busy equals whether any interrupt bit is set.
- R11: A read of 0x14 returns the current value and then clears TEST.
- R12: `irq` is high exactly when any interrupt control bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte address; only bits 5:0 are decoded |
| reg_rd | input | 1 | Read strobe; side effects apply at this edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| rx_valid | input | 1 | Receive byte present |
| rx_sop | input | 1 | Receive byte is the first of a frame |
| rx_eop | input | 1 | Receive byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Block takes receive beats |
| tx_valid | output | 1 | Transmit byte present |
| tx_sop | output | 1 | First byte of the transmit frame |
| tx_eop | output | 1 | Last byte of the transmit frame |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt, high while any control bit is set |

## Verification
The priority rule of R10 only shows when TXDONE and RXDONE are pending at the same time. The bench reaches that state by completing a one-byte receive frame and a one-byte transmit frame back to back before any acknowledge. It then writes codes that carry several bits at once.

The second case that is hard to reach is a receive count sitting at the limit while busy is already low. That state arises only after a full-size or oversize frame has been acknowledged but not yet drained. The receive sweep stops there on every frame of length `MAX_FRAME` or more and offers one more frame, which must be refused.

Writes during playback need the host accesses to land inside the output burst. The bench therefore reprograms the count and writes bytes right after the final byte of a maximum-length frame.

// File: rtl/fmbx_pkg.sv
`timescale 1ns/1ps
package fmbx_pkg;

    typedef enum logic { RX_IDLE, RX_CAPTURE } rx_state_e;
    typedef enum logic { TX_FILL, TX_PLAY }    tx_state_e;

    // Byte offsets seen by the host (low 6 address bits)
    localparam logic [5:0] OFF_ID0    = 6'h00;
    localparam logic [5:0] OFF_ID1    = 6'h04;
    localparam logic [5:0] OFF_BUSY   = 6'h08;
    localparam logic [5:0] OFF_RXCNT  = 6'h0C;
    localparam logic [5:0] OFF_TXCNT  = 6'h10;
    localparam logic [5:0] OFF_INTCTL = 6'h14;
    localparam logic [5:0] OFF_INFO   = 6'h18;
    localparam logic [5:0] OFF_RXDATA = 6'h1C;
    localparam logic [5:0] OFF_TXDATA = 6'h20;

    // Packed storage index of each interrupt flag
    localparam int IC_TX  = 0;
    localparam int IC_RX  = 1;
    localparam int IC_TST = 2;

    // Host-visible bit position of each interrupt flag
    localparam int HB_TX  = 0;
    localparam int HB_RX  = 1;
    localparam int HB_TST = 31;

endpackage

// File: rtl/fmbx_rx_buf.sv
`timescale 1ns/1ps
module fmbx_rx_buf
    import fmbx_pkg::*;
#(
    parameter int MAX_FRAME = 1514,
    parameter int CNT_W     = $clog2(MAX_FRAME + 1),
    parameter int PTR_W     = $clog2(MAX_FRAME)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             busy,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic             pop,
    output logic [CNT_W-1:0] count,
    output logic [7:0]       head_byte,
    output logic             commit
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_FRAME);

    rx_state_e        state_q, state_d;
    logic [7:0]       mem [MAX_FRAME];
    logic [CNT_W-1:0] len_q, cur_len, len_d, cnt_q;
    logic [PTR_W-1:0] rptr_q;
    logic             can_take, start, beat, store;

    always_comb begin
        can_take  = !busy && (cnt_q < MAX_C);
        start     = (state_q == RX_IDLE) && in_valid && in_sop && can_take;
        beat      = start || ((state_q == RX_CAPTURE) && in_valid);
        cur_len   = (state_q == RX_IDLE) ? '0 : len_q;
        store     = beat && (cur_len < MAX_C) && !soft_clr;
        len_d     = (cur_len < MAX_C) ? cur_len + 1'b1 : cur_len;
        commit    = beat && in_eop && !soft_clr;
        in_ready  = (state_q == RX_CAPTURE) || can_take;
        count     = cnt_q;
        head_byte = mem[rptr_q];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:    if (start && !in_eop)    state_d = RX_CAPTURE;
            RX_CAPTURE: if (in_valid && in_eop)  state_d = RX_IDLE;
            default:                             state_d = RX_IDLE;
        endcase
        if (soft_clr) state_d = RX_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            if (beat) len_q <= len_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            cnt_q  <= '0;
            rptr_q <= '0;
        end else if (commit) begin
            cnt_q  <= len_d;
            rptr_q <= '0;
        end else if (pop && (cnt_q != '0)) begin
            cnt_q  <= cnt_q - 1'b1;
            rptr_q <= rptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (store) mem[cur_len[PTR_W-1:0]] <= in_data;
    end

endmodule

// File: rtl/fmbx_tx_buf.sv
`timescale 1ns/1ps
module fmbx_tx_buf
    import fmbx_pkg::*;
#(
    parameter int MAX_FRAME = 1514,
    parameter int CNT_W     = $clog2(MAX_FRAME + 1),
    parameter int PTR_W     = $clog2(MAX_FRAME)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             len_wr,
    input  logic [31:0]      len_val,
    input  logic             data_wr,
    input  logic [7:0]       data_byte,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop,
    output logic [7:0]       out_data
);

    tx_state_e        st_q, st_d;
    logic [7:0]       mem [MAX_FRAME];
    logic [CNT_W-1:0] cnt_q, wptr_q, plen_q, pptr_q, len_load;
    logic             accept, fire, play_last;

    always_comb begin
        len_load  = (len_val <= 32'(MAX_FRAME)) ? len_val[CNT_W-1:0] : '0;
        accept    = data_wr && !len_wr && !soft_clr && (st_q == TX_FILL) && (cnt_q != '0);
        fire      = accept && ((wptr_q + 1'b1) == cnt_q);
        play_last = (st_q == TX_PLAY) && ((pptr_q + 1'b1) == plen_q);
        done      = fire;
        count     = cnt_q;
    end

    always_comb begin
        out_valid = (st_q == TX_PLAY);
        out_sop   = out_valid && (pptr_q == '0);
        out_eop   = play_last;
        out_data  = out_valid ? mem[pptr_q[PTR_W-1:0]] : 8'h00;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_FILL: if (fire)      st_d = TX_PLAY;
            TX_PLAY: if (play_last) st_d = TX_FILL;
            default:                st_d = TX_FILL;
        endcase
        if (soft_clr) st_d = TX_FILL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TX_FILL;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            cnt_q  <= '0;
            wptr_q <= '0;
            plen_q <= '0;
            pptr_q <= '0;
        end else begin
            if (len_wr) begin
                cnt_q  <= len_load;
                wptr_q <= '0;
            end else if (fire) begin
                cnt_q  <= '0;
                wptr_q <= '0;
            end else if (accept) begin
                wptr_q <= wptr_q + 1'b1;
            end
            if (fire) begin
                plen_q <= cnt_q;
                pptr_q <= '0;
            end else if (st_q == TX_PLAY) begin
                pptr_q <= pptr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (accept) mem[wptr_q[PTR_W-1:0]] <= data_byte;
    end

endmodule

// File: rtl/fmbx_nic.sv
`timescale 1ns/1ps
module fmbx_nic
    import fmbx_pkg::*;
#(
    parameter int          MAX_FRAME = 1514,
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] ID_WORD0  = 32'h464D_4258,
    parameter logic [31:0] ID_WORD1  = 32'h4E49_4330
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic [7:0]        tx_data,
    output logic              irq
);

    localparam int CNT_W = $clog2(MAX_FRAME + 1);
    localparam int PTR_W = $clog2(MAX_FRAME);

    logic [5:0]       off;
    logic             ic_rd, ic_wr, soft_clr, rx_pop, tx_len_wr, tx_data_wr;
    logic             rx_commit, tx_done;
    logic [CNT_W-1:0] rx_cnt, tx_cnt;
    logic [7:0]       rx_head;
    logic [2:0]       ic_q, ic_d;
    logic             busy_q, busy_d;
    logic [31:0]      rd_val;

    generate
        if (ADDR_W > 6) begin : g_hi_addr
            logic unused_hi;
            assign unused_hi = ^reg_addr[ADDR_W-1:6];
        end
    endgenerate

    always_comb begin
        off        = reg_addr[5:0];
        ic_rd      = reg_rd && (off == OFF_INTCTL);
        ic_wr      = reg_wr && (off == OFF_INTCTL);
        soft_clr   = ic_wr && !reg_wdata[HB_TX] && !reg_wdata[HB_RX] && reg_wdata[HB_TST];
        rx_pop     = reg_rd && (off == OFF_RXDATA);
        tx_len_wr  = reg_wr && (off == OFF_TXCNT);
        tx_data_wr = reg_wr && (off == OFF_TXDATA);
    end

    fmbx_rx_buf #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .busy      (busy_q),
        .in_valid  (rx_valid),
        .in_sop    (rx_sop),
        .in_eop    (rx_eop),
        .in_data   (rx_data),
        .in_ready  (rx_ready),
        .pop       (rx_pop),
        .count     (rx_cnt),
        .head_byte (rx_head),
        .commit    (rx_commit)
    );

    fmbx_tx_buf #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .len_wr    (tx_len_wr),
        .len_val   (reg_wdata),
        .data_wr   (tx_data_wr),
        .data_byte (reg_wdata[7:0]),
        .count     (tx_cnt),
        .done      (tx_done),
        .out_valid (tx_valid),
        .out_sop   (tx_sop),
        .out_eop   (tx_eop),
        .out_data  (tx_data)
    );

    // Read multiplexer
    always_comb begin
        rd_val = '0;
        case (off)
            OFF_ID0:    rd_val = ID_WORD0;
            OFF_ID1:    rd_val = ID_WORD1;
            OFF_BUSY:   rd_val = {31'b0, busy_q};
            OFF_RXCNT:  rd_val = 32'(rx_cnt);
            OFF_TXCNT:  rd_val = 32'(tx_cnt);
            OFF_INTCTL: rd_val = {ic_q[IC_TST], 29'b0, ic_q[IC_RX], ic_q[IC_TX]};
            OFF_RXDATA: rd_val = (rx_cnt != '0) ? {24'b0, rx_head} : 32'b0;
            default:    rd_val = '0;
        endcase
    end

    // Interrupt control and busy update
    always_comb begin
        ic_d = ic_q;
        if (ic_rd) ic_d[IC_TST] = 1'b0;
        if (ic_wr) begin
            if (reg_wdata[HB_TX])       ic_d[IC_TX] = 1'b0;
            else if (reg_wdata[HB_RX])  ic_d[IC_RX] = 1'b0;
            else if (reg_wdata[HB_TST]) begin
                ic_d         = '0;
                ic_d[IC_TST] = 1'b1;
            end
        end
        if (!soft_clr) begin
            if (tx_done)   ic_d[IC_TX] = 1'b1;
            if (rx_commit) ic_d[IC_RX] = 1'b1;
        end
        busy_d = busy_q;
        if (ic_wr)                     busy_d = |ic_d;
        else if (tx_done || rx_commit) busy_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ic_q      <= '0;
            busy_q    <= 1'b1;
            reg_rdata <= '0;
        end else begin
            ic_q   <= ic_d;
            busy_q <= busy_d;
            if (reg_rd) reg_rdata <= rd_val;
        end
    end

    assign irq = |ic_q;

endmodule

// File: rtl/fmbx_nic_chk.sv
`timescale 1ns/1ps
module fmbx_nic_chk #(
    parameter int MAX_FRAME = 1514,
    parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             irq,
    input logic             soft_clr,
    input logic             rx_commit,
    input logic             tx_done,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic             tx_valid,
    input logic             tx_sop,
    input logic             tx_eop
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_FRAME);

    a_r4_commit_raises: assert property (@(posedge clk) disable iff (!rst_n)
        rx_commit |=> (busy && irq));

    a_r6_rx_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= MAX_C);

    a_r7_tx_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= MAX_C);

    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> (busy && irq && tx_count == '0));

    a_r9_sop_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sop |-> tx_valid);

    a_r9_eop_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_eop) |=> !tx_valid);

    a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (busy && irq && rx_count == '0 && tx_count == '0));

    a_r12_irq_busy: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> busy);

endmodule

bind fmbx_nic fmbx_nic_chk #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_q),
    .irq       (irq),
    .soft_clr  (soft_clr),
    .rx_commit (rx_commit),
    .tx_done   (tx_done),
    .rx_count  (rx_cnt),
    .tx_count  (tx_cnt),
    .tx_valid  (tx_valid),
    .tx_sop    (tx_sop),
    .tx_eop    (tx_eop)
);

// File: tb/tb_fmbx_nic.sv
`timescale 1ns/1ps
module tb_fmbx_nic;

    localparam int          MAXF = 16;
    localparam logic [31:0] ID0  = 32'h5445_5354;
    localparam logic [31:0] ID1  = 32'h4E49_4331;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, tx_sop, tx_eop, irq;
    logic [7:0]  tx_data;

    int tests = 0;
    int fails = 0;

    fmbx_nic #(.MAX_FRAME(MAXF), .ADDR_W(8), .ID_WORD0(ID0), .ID_WORD1(ID1)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_data(tx_data), .irq(irq)
    );

    always #2 clk = ~clk;

    // Transmit monitor
    logic [7:0] cap [64];
    int ncap = 0, sops = 0, eops = 0, sop_at = -1, eop_at = -1;
    int cyc = 0, first_cyc = 0, last_cyc = 0;
    always @(negedge clk) begin
        cyc++;
        if (tx_valid) begin
            if (ncap < 64) cap[ncap] = tx_data;
            if (tx_sop) begin sops++; sop_at = ncap; end
            if (tx_eop) begin eops++; eop_at = ncap; end
            if (ncap == 0) first_cyc = cyc;
            last_cyc = cyc;
            ncap++;
        end
    end

    task automatic clear_cap();
        ncap = 0; sops = 0; eops = 0; sop_at = -1; eop_at = -1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] rxb(input int seed, input int i);
        return 8'(seed * 5 + i * 3 + 1);
    endfunction

    function automatic logic [7:0] txb(input int seed, input int i);
        return 8'(seed * 11 + i * 7 + 3);
    endfunction

    task automatic send(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sop = (i == 0); rx_eop = (i == len - 1); rx_data = rxb(seed, i);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    endtask

    task automatic chk_frame(input string req, input int len, input int seed);
        chk({req, " length"}, 32'(ncap), 32'(len));
        chk({req, " markers"}, {sops == 1, eops == 1, sop_at == 0, eop_at == len - 1}, 4'hF);
        chk({req, " back-to-back"}, 32'(last_cyc - first_cyc), 32'(len - 1));
        for (int i = 0; i < len && i < 64; i++)
            chk({req, " byte"}, 32'(cap[i]), 32'(txb(seed, i)));
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int exp_len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1, R2: reset values over every word offset, then aliases
        for (int o = 0; o < 64; o += 4) begin
            rd(8'(o), v);
            chk("R1 R2 reset read", v, (o == 0) ? ID0 : (o == 4) ? ID1 : (o == 8) ? 32'd1 : 32'd0);
        end
        rd(8'h48, v);  chk("R2 alias busy", v, 32'd1);
        rd(8'hC4, v);  chk("R2 alias id1", v, ID1);
        rd(8'h09, v);  chk("R2 unaligned", v, 32'd0);
        chk("R12 irq at reset", 32'(irq), 32'd0);
        chk("R3 ready while busy", 32'(rx_ready), 32'd0);

        wr(8'h14, 32'd0);
        rd(8'h08, v);  chk("R10 zero write drops busy", v, 32'd0);
        chk("R3 ready when free", 32'(rx_ready), 32'd1);

        // R2: read-only and unmapped writes
        foreach (v[i]) begin end
        wr(8'h00, '1); wr(8'h04, '1); wr(8'h08, '1); wr(8'h0C, '1);
        wr(8'h18, '1); wr(8'h1C, '1); wr(8'h24, '1); wr(8'h3C, '1);
        rd(8'h00, v);  chk("R2 id0 kept", v, ID0);
        rd(8'h04, v);  chk("R2 id1 kept", v, ID1);
        rd(8'h08, v);  chk("R2 busy kept", v, 32'd0);
        rd(8'h0C, v);  chk("R2 rx count kept", v, 32'd0);
        rd(8'h18, v);  chk("R2 info zero", v, 32'd0);
        rd(8'h10, v);  chk("R2 tx count kept", v, 32'd0);
        chk("R2 irq kept", 32'(irq), 32'd0);

        // R3: beat without start marker in idle is dropped
        @(negedge clk); rx_valid = 1'b1; rx_sop = 1'b0; rx_eop = 1'b1; rx_data = 8'h5A;
        @(negedge clk); rx_valid = 1'b0; rx_eop = 1'b0;
        rd(8'h0C, v);  chk("R3 stray beat count", v, 32'd0);
        chk("R3 stray beat irq", 32'(irq), 32'd0);

        // R4 R5 R6: receive length sweep
        for (int len = 1; len <= MAXF + 3; len++) begin
            send(len, len);
            exp_len = (len < MAXF) ? len : MAXF;
            rd(8'h0C, v);  chk("R4 R6 rx count", v, 32'(exp_len));
            rd(8'h14, v);  chk("R4 rxdone", v, 32'h2);
            rd(8'h08, v);  chk("R4 busy", v, 32'd1);
            chk("R12 irq on rx", 32'(irq), 32'd1);
            if (len == 2) begin
                send(4, 77);
                rd(8'h0C, v);  chk("R3 refused while busy", v, 32'd2);
            end
            if (len >= MAXF) begin
                wr(8'h14, 32'h2);
                chk("R3 ready low at full count", 32'(rx_ready), 32'd0);
                send(3, 99);
                rd(8'h0C, v);  chk("R3 refused at full count", v, 32'(MAXF));
                rd(8'h14, v);  chk("R3 no commit at full count", v, 32'd0);
            end
            for (int i = 0; i < exp_len; i++) begin
                rd(8'h1C, v);  chk("R5 R6 rx byte", v, 32'(rxb(len, i)));
            end
            rd(8'h1C, v);  chk("R5 empty read", v, 32'd0);
            rd(8'h0C, v);  chk("R5 count drained", v, 32'd0);
            if (len < MAXF) wr(8'h14, 32'h2);
            rd(8'h08, v);  chk("R10 busy after rx ack", v, 32'd0);
            chk("R12 irq after rx ack", 32'(irq), 32'd0);
        end

        // R4: read position restarts on a new frame
        send(5, 40);
        wr(8'h14, 32'h2);
        rd(8'h1C, v); rd(8'h1C, v);
        send(3, 50);
        rd(8'h0C, v);  chk("R4 new count", v, 32'd3);
        for (int i = 0; i < 3; i++) begin
            rd(8'h1C, v);  chk("R4 restart byte", v, 32'(rxb(50, i)));
        end
        wr(8'h14, 32'h2);

        // R7: count load rule
        wr(8'h10, 32'd0);          rd(8'h10, v); chk("R7 count 0", v, 32'd0);
        wr(8'h10, 32'(MAXF));      rd(8'h10, v); chk("R7 count max", v, 32'(MAXF));
        wr(8'h10, 32'(MAXF + 1));  rd(8'h10, v); chk("R7 count over", v, 32'd0);
        wr(8'h10, 32'd7);          rd(8'h10, v); chk("R7 count 7", v, 32'd7);
        wr(8'h10, 32'hFFFF_FFFF);  rd(8'h10, v); chk("R7 count huge", v, 32'd0);
        wr(8'h10, 32'h0001_0005);  rd(8'h10, v); chk("R7 count high bits", v, 32'd0);

        // R8: data write with zero count is ignored
        clear_cap();
        wr(8'h20, 32'hAA);
        repeat (4) @(negedge clk);
        chk("R8 zero count no frame", 32'(ncap), 32'd0);
        rd(8'h14, v);  chk("R8 zero count no done", v, 32'd0);
        rd(8'h20, v);  chk("R2 tx buffer reads zero", v, 32'd0);

        // R8 R9: transmit length sweep
        for (int len = 1; len <= MAXF; len++) begin
            wr(8'h10, 32'(len));
            clear_cap();
            for (int i = 0; i < len; i++) wr(8'h20, {24'hABCDEF, txb(len, i)});
            repeat (MAXF + 4) @(negedge clk);
            chk_frame("R8 R9 tx frame", len, len);
            rd(8'h10, v);  chk("R8 count cleared", v, 32'd0);
            rd(8'h14, v);  chk("R8 txdone", v, 32'h1);
            rd(8'h08, v);  chk("R8 busy", v, 32'd1);
            wr(8'h14, 32'h1);
            rd(8'h14, v);  chk("R10 tx ack", v, 32'd0);
            rd(8'h08, v);  chk("R10 busy after tx ack", v, 32'd0);
        end

        // R7: rewriting the count restarts the write position
        wr(8'h10, 32'd4);
        wr(8'h20, 32'h11); wr(8'h20, 32'h22);
        wr(8'h10, 32'd3);
        clear_cap();
        for (int i = 0; i < 3; i++) wr(8'h20, 32'(txb(7, i)));
        repeat (8) @(negedge clk);
        chk_frame("R7 restart", 3, 7);
        wr(8'h14, 32'h1);

        // R9: data writes during playback ignored, count write kept
        wr(8'h10, 32'(MAXF));
        clear_cap();
        for (int i = 0; i < MAXF; i++) wr(8'h20, 32'(txb(9, i)));
        wr(8'h10, 32'd2);
        wr(8'h20, 32'hE1); wr(8'h20, 32'hE2);
        repeat (MAXF + 4) @(negedge clk);
        chk_frame("R9 busy playback", MAXF, 9);
        rd(8'h10, v);  chk("R9 count kept", v, 32'd2);
        clear_cap();
        wr(8'h20, 32'(txb(3, 0))); wr(8'h20, 32'(txb(3, 1)));
        repeat (6) @(negedge clk);
        chk_frame("R9 after playback", 2, 3);
        wr(8'h14, 32'h1);

        // R10: priority with both done bits pending
        send(1, 5);
        wr(8'h10, 32'd1); wr(8'h20, 32'h42);
        repeat (3) @(negedge clk);
        rd(8'h14, v);  chk("R10 both pending", v, 32'h3);
        wr(8'h14, 32'h8000_0003);
        rd(8'h14, v);  chk("R10 bit0 first", v, 32'h2);
        rd(8'h0C, v);  chk("R10 no reset on bit0", v, 32'd1);
        wr(8'h14, 32'd0);
        rd(8'h14, v);  chk("R10 zero keeps bits", v, 32'h2);
        rd(8'h08, v);  chk("R10 zero keeps busy", v, 32'd1);
        wr(8'h14, 32'h8000_0002);
        rd(8'h14, v);  chk("R10 bit1 second", v, 32'd0);
        rd(8'h08, v);  chk("R10 busy follows bits", v, 32'd0);
        rd(8'h0C, v);  chk("R10 no reset on bit1", v, 32'd1);

        // R10 R11 R12: soft reset and self-test flag
        wr(8'h10, 32'd5);
        wr(8'h14, 32'h8000_0000);
        chk("R12 irq on test", 32'(irq), 32'd1);
        rd(8'h08, v);  chk("R10 soft reset busy", v, 32'd1);
        rd(8'h0C, v);  chk("R10 soft reset rx count", v, 32'd0);
        rd(8'h10, v);  chk("R10 soft reset tx count", v, 32'd0);
        rd(8'h14, v);  chk("R11 test visible", v, 32'h8000_0000);
        rd(8'h14, v);  chk("R11 test cleared by read", v, 32'd0);
        chk("R12 irq after test read", 32'(irq), 32'd0);
        rd(8'h08, v);  chk("R11 read keeps busy", v, 32'd1);
        wr(8'h14, 32'd0);
        rd(8'h08, v);  chk("R10 busy released", v, 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule